// File: doc/BRIEF.md
# Text Cell Pixel Pipeline

This block turns fetched text-mode cell data into a dot-rate colour stream. For each character cell, eight pixels wide, an external timing source presents one character code, one attribute byte and the current glyph row together with a one-cycle cell strobe. The block buffers the pair, fetches the glyph row from an internal character table, and loads that row into a shift register that advances once per clock. Each bit leaving the register picks either the foreground or the background colour index from the attribute. The picked index addresses a 16-entry colour table whose 12-bit entries drive the red, green and blue outputs.

The host can rewrite the colour table through a one-cycle write strobe. A write is applied at once only when blanking is active. A write made during active video is parked per entry and lands at the next rising edge of the blank input, so a palette change never tears a visible line. While blank is high the colour outputs are driven to zero. A full screen is meant to be 80 columns by 32 rows of 8x8 cells. The block itself works one cell at a time and does not count columns or rows.

Top module: `textcell_pixel_pipe`

## Requirements
- R1: After reset the colour outputs are zero, and colour table entry i holds the value i in each of its three 4-bit channels.
- R2: Attribute bits 7:4 are the foreground index and bits 3:0 the background index. A glyph bit of 1 shows the foreground entry and a 0 shows the background entry.
- R3: Code, attribute and row are sampled at the clock edge where cell_start is high. Glyph bit 7, the leftmost pixel, appears on the outputs after the second edge that follows. The remaining bits follow one per clock in descending order, so strobes eight cycles apart give a gapless stream.
- R4: The character table holds four glyphs. Code 0x01 is a checkerboard: rows with an even number give 0xAA and rows with an odd number give 0x55. Code 0x02 is a diagonal equal to 0x80 shifted right by the row number. Code 0x03 gives 0xFF on every row. Every other code gives 0x00.
- R5: A table write sampled while blank is high changes the entry at that edge.
- R6: A table write sampled while blank is low leaves the visible entry unchanged until the next rising edge of blank.
- R7: A second parked write to the same entry replaces the first parked value.
- R8: At every edge where blank is high, the colour outputs become zero after that edge, whatever the shift register holds.
- R9: At the edge where blank rises, all parked writes are committed. A write to the same entry sampled at that same edge wins over the parked value for that entry.
- R10: Entry bits 11:8 drive red, bits 7:4 drive green and bits 3:0 drive blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_start | input | 1 | One-cycle strobe marking a new cell's data |
| char_code | input | 8 | Character code of the cell |
| attr_byte | input | 8 | Foreground (7:4) and background (3:0) indices |
| glyph_row | input | 3 | Scanline row within the cell |
| blank | input | 1 | Blanking interval active |
| pal_we | input | 1 | Colour table write strobe |
| pal_idx | input | 4 | Colour table entry to write |
| pal_rgb | input | 12 | New entry value, red in bits 11:8 |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |

## Verification
Two functions can land in the same cycle: committing parked palette writes at the rising edge of blank, and a fresh write that arrives during blanking. The bench parks writes to two entries during active video. It then raises blank in the same cycle that a new write hits one of those two entries. After blanking ends, it renders cells that use each entry. The colliding entry must show the fresh value and the other entry must show its parked value.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;
  localparam int GLYPH_W = 8;
  localparam int IDX_W   = 4;
  localparam int ROW_W   = 3;
  localparam int CODE_W  = 8;

  typedef struct packed {
    logic [IDX_W-1:0] fg;
    logic [IDX_W-1:0] bg;
  } cell_attr_t;
endpackage

// File: rtl/txt_glyph_rom.sv
module txt_glyph_rom
  import txtvid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [ROW_W-1:0]  row,
  output logic [GLYPH_W-1:0] glyph_q
);
  logic [GLYPH_W-1:0] glyph_d;

  // Character table: one entry per code and row.
  always_comb begin
    glyph_d = '0;
    case (code)
      CODE_W'(1): glyph_d = row[0] ? 8'h55 : 8'hAA;
      CODE_W'(2): begin
        case (row)
          3'd0: glyph_d = 8'h80;
          3'd1: glyph_d = 8'h40;
          3'd2: glyph_d = 8'h20;
          3'd3: glyph_d = 8'h10;
          3'd4: glyph_d = 8'h08;
          3'd5: glyph_d = 8'h04;
          3'd6: glyph_d = 8'h02;
          default: glyph_d = 8'h01;
        endcase
      end
      CODE_W'(3): glyph_d = 8'hFF;
      default:    glyph_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  glyph_q <= '0;
    else if (en) glyph_q <= glyph_d;
  end
endmodule

// File: rtl/txt_cell_shifter.sv
module txt_cell_shifter
  import txtvid_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cell_start,
  input  cell_attr_t         attr_in,
  input  logic [GLYPH_W-1:0] glyph_in,
  output logic [IDX_W-1:0]   pix_idx
);
  localparam int GAP_W = $clog2(GLYPH_W) + 1;

  cell_attr_t         attr_buf, attr_buf_nxt;
  cell_attr_t         attr_cur, attr_cur_nxt;
  logic               load_q;
  logic [GLYPH_W-1:0] sh, sh_nxt;
  logic [GAP_W-1:0]   gap, gap_nxt;

  always_comb begin
    attr_buf_nxt = cell_start ? attr_in : attr_buf;
    attr_cur_nxt = attr_cur;
    sh_nxt       = sh << 1;
    if (load_q) begin
      sh_nxt       = glyph_in;
      attr_cur_nxt = attr_buf;
    end
    if (cell_start)                        gap_nxt = '0;
    else if (gap < GAP_W'(GLYPH_W - 1))    gap_nxt = gap + 1'b1;
    else                                   gap_nxt = gap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_buf <= '0;
      attr_cur <= '0;
      load_q   <= 1'b0;
      sh       <= '0;
      gap      <= GAP_W'(GLYPH_W - 1);
    end else begin
      attr_buf <= attr_buf_nxt;
      attr_cur <= attr_cur_nxt;
      load_q   <= cell_start;
      sh       <= sh_nxt;
      gap      <= gap_nxt;
    end
  end

  assign pix_idx = sh[GLYPH_W-1] ? attr_cur.fg : attr_cur.bg;

  // Cells must not arrive faster than one per eight dots.
  assert_cell_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |-> (gap == GAP_W'(GLYPH_W - 1)));
endmodule

// File: rtl/txt_palette.sv
module txt_palette
  import txtvid_pkg::*;
#(
  parameter int CHAN_W = 4,
  localparam int ENTRY_W = 3 * CHAN_W,
  localparam int DEPTH   = 1 << IDX_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blank,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rgb_q
);
  logic [ENTRY_W-1:0] tbl    [DEPTH];
  logic [ENTRY_W-1:0] tbl_nxt[DEPTH];
  logic [ENTRY_W-1:0] pend_d    [DEPTH];
  logic [ENTRY_W-1:0] pend_d_nxt[DEPTH];
  logic [DEPTH-1:0]   pend_v, pend_v_nxt;
  logic               blank_q;
  logic               blank_rise;
  logic [ENTRY_W-1:0] rgb_nxt;

  assign blank_rise = blank & ~blank_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      tbl_nxt[i]    = tbl[i];
      pend_d_nxt[i] = pend_d[i];
      pend_v_nxt[i] = pend_v[i];
      if (blank_rise && pend_v[i]) begin
        tbl_nxt[i]    = pend_d[i];
        pend_v_nxt[i] = 1'b0;
      end
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        if (blank) begin
          tbl_nxt[i]    = wr_data;
          pend_v_nxt[i] = 1'b0;
        end else begin
          pend_d_nxt[i] = wr_data;
          pend_v_nxt[i] = 1'b1;
        end
      end
    end
    rgb_nxt = blank ? '0 : tbl[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl[i]    <= {3{CHAN_W'(i)}};
        pend_d[i] <= '0;
      end
      pend_v  <= '0;
      blank_q <= 1'b0;
      rgb_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl[i]    <= tbl_nxt[i];
        pend_d[i] <= pend_d_nxt[i];
      end
      pend_v  <= pend_v_nxt;
      blank_q <= blank;
      rgb_q   <= rgb_nxt;
    end
  end

  // Entries only ever change on an edge that saw blanking.
  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    assert_entry_change_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tbl[g]) |-> $past(blank));
  end

  // Nothing stays parked after blanking starts.
  assert_commit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_rise |=> (pend_v == '0));
endmodule

// File: rtl/textcell_pixel_pipe.sv
module textcell_pixel_pipe
  import txtvid_pkg::*;
#(
  parameter int CHAN_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_start,
  input  logic [7:0]        char_code,
  input  logic [7:0]        attr_byte,
  input  logic [2:0]        glyph_row,
  input  logic              blank,
  input  logic              pal_we,
  input  logic [3:0]        pal_idx,
  input  logic [11:0]       pal_rgb,
  output logic [CHAN_W-1:0] red,
  output logic [CHAN_W-1:0] green,
  output logic [CHAN_W-1:0] blue
);
  localparam int ENTRY_W = 3 * CHAN_W;

  logic [GLYPH_W-1:0] glyph_q;
  logic [IDX_W-1:0]   pix_idx;
  logic [ENTRY_W-1:0] rgb_q;

  txt_glyph_rom u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cell_start),
    .code    (char_code),
    .row     (glyph_row),
    .glyph_q (glyph_q)
  );

  txt_cell_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .attr_in    (cell_attr_t'(attr_byte)),
    .glyph_in   (glyph_q),
    .pix_idx    (pix_idx)
  );

  txt_palette #(.CHAN_W(CHAN_W)) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank   (blank),
    .wr_en   (pal_we),
    .wr_idx  (pal_idx),
    .wr_data (pal_rgb),
    .rd_idx  (pix_idx),
    .rgb_q   (rgb_q)
  );

  assign red   = rgb_q[ENTRY_W-1 -: CHAN_W];
  assign green = rgb_q[2*CHAN_W-1 -: CHAN_W];
  assign blue  = rgb_q[CHAN_W-1:0];

  assert_blank_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> ({red, green, blue} == '0));
endmodule

// File: tb/textcell_pixel_pipe_tb.sv
module textcell_pixel_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cell_start, blank, pal_we;
  logic [7:0]  char_code, attr_byte;
  logic [2:0]  glyph_row;
  logic [3:0]  pal_idx;
  logic [11:0] pal_rgb;
  logic [3:0]  red, green, blue;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [11:0] pal_m [16];

  localparam int NV = 8;
  localparam logic [7:0] V_CODE [NV] = '{8'h01, 8'h01, 8'h02, 8'h02, 8'h03, 8'h00, 8'h7F, 8'h02};
  localparam logic [2:0] V_ROW  [NV] = '{3'd0, 3'd1, 3'd0, 3'd5, 3'd2, 3'd3, 3'd4, 3'd7};
  localparam logic [7:0] V_ATTR [NV] = '{8'h5A, 8'h5A, 8'hF0, 8'h3C, 8'h71, 8'h9E, 8'hE2, 8'h1F};
  localparam logic [7:0] V_GLY  [NV] = '{8'hAA, 8'h55, 8'h80, 8'h04, 8'hFF, 8'h00, 8'h00, 8'h01};

  always #10 clk = ~clk;

  textcell_pixel_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .char_code(char_code),
    .attr_byte(attr_byte), .glyph_row(glyph_row), .blank(blank),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .red(red), .green(green), .blue(blue)
  );

  function automatic logic [7:0] glyph_of(input logic [7:0] c, input logic [2:0] r);
    case (c)
      8'h01:   return r[0] ? 8'h55 : 8'hAA;
      8'h02:   return 8'h80 >> r;
      8'h03:   return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic pal_write(input logic [3:0] i, input logic [11:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_idx = i; pal_rgb = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic run_cell(input logic [7:0] c, input logic [2:0] r, input logic [7:0] a,
                          input logic blk, input string tag);
    logic [7:0] g;
    g = glyph_of(c, r);
    @(negedge clk);
    cell_start = 1'b1; char_code = c; glyph_row = r; attr_byte = a; blank = blk;
    @(negedge clk);
    cell_start = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(tag, {red, green, blue},
            blk ? 12'h000 : (g[7-k] ? pal_m[a[7:4]] : pal_m[a[3:0]]));
    end
    blank = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) pal_m[i] = 12'(i * 12'h111);
    rst_n = 1'b0; cell_start = 0; blank = 0; pal_we = 0;
    char_code = 0; attr_byte = 0; glyph_row = 0; pal_idx = 0; pal_rgb = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {red, green, blue}, 12'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", {red, green, blue}, 12'h000);

    // Back-to-back vector walk over the default palette (R1 R2 R3 R4).
    for (int t = 0; t < 8 * NV + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        int p, ci, k;
        p = t - 3; ci = p / 8; k = p % 8;
        check("R2 R3 R4 vector", {red, green, blue},
              V_GLY[ci][7-k] ? pal_m[V_ATTR[ci][7:4]] : pal_m[V_ATTR[ci][3:0]]);
      end
      if ((t % 8 == 0) && (t / 8 < NV)) begin
        cell_start = 1'b1; char_code = V_CODE[t/8];
        glyph_row = V_ROW[t/8]; attr_byte = V_ATTR[t/8];
      end else cell_start = 1'b0;
    end

    // R8: blank forces black over a solid glyph.
    run_cell(8'h03, 3'd0, 8'hF0, 1'b1, "R8 blank");

    // R6: write during active video stays parked.
    pal_write(4'd5, 12'hF00);
    run_cell(8'h03, 3'd0, 8'h50, 1'b0, "R6 parked");
    // R7: second parked write replaces the first; R10 channel order.
    pal_write(4'd5, 12'h0F0);
    @(negedge clk) blank = 1'b1;
    @(negedge clk) blank = 1'b0;
    pal_m[5] = 12'h0F0;
    run_cell(8'h03, 3'd0, 8'h50, 1'b0, "R7 R10 replaced");
    check("R10 green only", {8'h00, green}, 12'h00F);

    // R9: commit and fresh write in the same cycle.
    pal_write(4'd9, 12'h123);
    pal_write(4'd10, 12'h456);
    @(negedge clk);
    blank = 1'b1; pal_we = 1'b1; pal_idx = 4'd9; pal_rgb = 12'hABC;
    @(negedge clk);
    pal_we = 1'b0; blank = 1'b0;
    pal_m[9] = 12'hABC; pal_m[10] = 12'h456;
    run_cell(8'h03, 3'd1, 8'h9A, 1'b0, "R9 collide fresh wins");
    run_cell(8'h00, 3'd0, 8'h9A, 1'b0, "R9 other committed");

    // R5: write inside blanking applies directly.
    @(negedge clk) blank = 1'b1;
    pal_write(4'd3, 12'h00F);
    @(negedge clk) blank = 1'b0;
    pal_m[3] = 12'h00F;
    run_cell(8'h01, 3'd0, 8'h3C, 1'b0, "R5 direct");
    run_cell(8'h55, 3'd6, 8'h3C, 1'b0, "R4 unlisted code");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule